// File: doc/BRIEF.md
# Signed/Unsigned Multiply-Accumulate Datapath

This block multiplies two 16-bit operands and keeps the answer in a 35-bit result register. The operands can be read as two's-complement or as unsigned numbers. Each operand has its own register and its own load strobe. A third strobe moves the product into the result register. Depending on the mode, the product either replaces the stored value, is added to it, or has the stored value subtracted from it. A rounding option adds one half of a least-significant-half unit before the product is combined, so that the upper 19 bits come out rounded.

Four mode bits sit in a small control register: accumulate, subtract, two's-complement and round. This register loads whenever either operand register loads. A later product strobe therefore uses the modes that were captured with the operands, not the mode inputs present at that moment.

The result has three fields: a 3-bit guard extension, a 16-bit high half and a 16-bit low half. A parallel preload input writes any 35-bit value into the result register, which seeds a running sum. Everything runs on one clock, with load-enable strobes and a synchronous reset.

Top module: `mac_unit`

## Requirements
- R1: A synchronous reset clears both operand registers, the mode register and the result register to zero.
- R2: The X operand register loads xIn only when loadX is high, and the Y operand register loads yIn only when loadY is high. An operand whose strobe is low keeps its value.
- R3: The mode register captures accEn, subEn, signedMode and roundEn in any cycle where loadX or loadY is high, and holds them in every other cycle.
- R4: The result register changes only on a cycle with loadP or preload high. Otherwise it holds its value.
- R5: With the latched accumulate mode at 0, a loadP writes the product (plus the rounding term) to the result, and the subtract mode has no effect.
- R6: With accumulate at 0, the 32-bit product fills bits 31:0. Bits 34:32 are the sign extension of the product in signed mode (signedMode=1) and zero in unsigned mode (signedMode=0).
- R7: In signed mode, -32768 x -32768 gives +2^30, with bits 34:31 all zero.
- R8: With accumulate at 1 and subtract at 0, the new result is the product plus the previous result. With accumulate at 1 and subtract at 1, the new result is the product minus the previous result.
- R9: With the latched round mode at 1, 2^15 is added to the product before it is stored or combined.
- R10: All accumulation wraps modulo 2^35 without any flag.
- R11: preload writes preloadValue into the result register. When preload and loadP are high in the same cycle, preload wins.
- R12: resultExt is result bits 34:32, resultHigh is bits 31:16 and resultLow is bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| loadX | input | 1 | Load strobe for the X operand register |
| loadY | input | 1 | Load strobe for the Y operand register |
| loadP | input | 1 | Product strobe that updates the result register |
| preload | input | 1 | Writes preloadValue into the result register |
| xIn | input | 16 | X operand |
| yIn | input | 16 | Y operand |
| accEn | input | 1 | Accumulate mode, captured with an operand load |
| subEn | input | 1 | Subtract mode, captured with an operand load |
| signedMode | input | 1 | 1 = two's complement, 0 = unsigned; captured with an operand load |
| roundEn | input | 1 | Round mode, captured with an operand load |
| preloadValue | input | 35 | Value written by preload |
| resultExt | output | 3 | Result bits 34:32 |
| resultHigh | output | 16 | Result bits 31:16 |
| resultLow | output | 16 | Result bits 15:0 |

## Verification
Some behaviours are checked by assertions on every cycle:
- The result holds when no strobe is present.
- The operand and mode registers hold without their strobes.
- Preload wins over the product strobe.
- A non-accumulating product leaves the guard bits either zeroed or as a clean sign extension.

Other behaviours only the bench scenarios can show:
- Arithmetic correctness of the product, which the bench sweeps over corner operands in both signedness modes, with and without rounding.
- Add and subtract ordering.
- Wrap at 2^35.
- Use of latched rather than live modes.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Strobes issued by the control unit to the datapath
  typedef struct packed {
    logic [1:0] loadOperand;   // [0] = X register, [1] = Y register
    logic       updateResult;  // arithmetic write of the result register
    logic       preloadResult; // external write of the result register
  } macStrobes_t;

  // Latched arithmetic modes
  typedef struct packed {
    logic accumulate;
    logic subtract;
    logic twosComp;
    logic round;
  } macModes_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        loadX,
  input  logic        loadY,
  input  logic        loadP,
  input  logic        preload,
  input  logic        accEn,
  input  logic        subEn,
  input  logic        signedMode,
  input  logic        roundEn,
  output macStrobes_t strobes,
  output macModes_t   modes
);

  logic      modeLoad;
  macModes_t modeReg;

  assign modeLoad = loadX | loadY;

  always_comb begin
    strobes.loadOperand   = {loadY, loadX};
    strobes.preloadResult = preload;
    strobes.updateResult  = loadP & ~preload;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg <= '0;
    end else if (modeLoad) begin
      modeReg.accumulate <= accEn;
      modeReg.subtract   <= subEn;
      modeReg.twosComp   <= signedMode;
      modeReg.round      <= roundEn;
    end
  end

  assign modes = modeReg;

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(loadX || loadY) |=> $stable(modeReg)); // R3

  AST_MODE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (loadX || loadY) |=> modeReg == {$past(accEn), $past(subEn), $past(signedMode), $past(roundEn)}); // R3

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(strobes.updateResult && strobes.preloadResult)); // R11

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  macStrobes_t                     strobes,
  input  macModes_t                       modes,
  input  logic [DATA_W-1:0]               xIn,
  input  logic [DATA_W-1:0]               yIn,
  input  logic [2*DATA_W+GUARD_W-1:0]     preloadValue,
  output logic [2*DATA_W+GUARD_W-1:0]     result
);

  localparam int PROD_W  = 2 * DATA_W;
  localparam int ACC_W   = PROD_W + GUARD_W;
  localparam int EXT_W   = ACC_W - DATA_W;
  localparam int RND_POS = DATA_W - 1;

  logic [DATA_W-1:0] opIn  [2];
  logic [DATA_W-1:0] opReg [2];
  logic [ACC_W-1:0]  opWide[2];
  logic [ACC_W-1:0]  product;
  logic [ACC_W-1:0]  roundTerm;
  logic [ACC_W-1:0]  rounded;
  logic [ACC_W-1:0]  combined;
  logic [ACC_W-1:0]  resultReg;

  assign opIn[0] = xIn;
  assign opIn[1] = yIn;

  // Each operand gets its own register and its own width extension
  for (genvar i = 0; i < 2; i++) begin : g_operand
    always_ff @(posedge clk) begin
      if (rst) begin
        opReg[i] <= '0;
      end else if (strobes.loadOperand[i]) begin
        opReg[i] <= opIn[i];
      end
    end

    // Extend to the full accumulator width, so one modulo-2^ACC_W multiply
    // serves both signed and unsigned operands
    assign opWide[i] = {{EXT_W{modes.twosComp & opReg[i][DATA_W-1]}}, opReg[i]};

    AST_OPERAND_HOLD: assert property (@(posedge clk) disable iff (rst)
      !strobes.loadOperand[i] |=> $stable(opReg[i])); // R2
  end

  assign product = opWide[0] * opWide[1];

  always_comb begin
    roundTerm          = '0;
    roundTerm[RND_POS] = modes.round;
  end

  assign rounded = product + roundTerm;

  always_comb begin
    if (!modes.accumulate) begin
      combined = rounded;
    end else if (modes.subtract) begin
      combined = rounded - resultReg;
    end else begin
      combined = rounded + resultReg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultReg <= '0;
    end else if (strobes.preloadResult) begin
      resultReg <= preloadValue;
    end else if (strobes.updateResult) begin
      resultReg <= combined;
    end
  end

  assign result = resultReg;

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(strobes.updateResult || strobes.preloadResult) |=> $stable(resultReg)); // R4

  AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    strobes.preloadResult |=> resultReg == $past(preloadValue)); // R11

  AST_UNSIGNED_GUARD: assert property (@(posedge clk) disable iff (rst)
    (strobes.updateResult && !modes.accumulate && !modes.twosComp)
      |=> resultReg[ACC_W-1:PROD_W] == '0); // R6

  AST_SIGNED_GUARD: assert property (@(posedge clk) disable iff (rst)
    (strobes.updateResult && !modes.accumulate && modes.twosComp)
      |=> ($countones(resultReg[ACC_W-1:PROD_W-1]) == 0 ||
           $countones(resultReg[ACC_W-1:PROD_W-1]) == GUARD_W + 1)); // R6

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        loadX,
  input  logic                        loadY,
  input  logic                        loadP,
  input  logic                        preload,
  input  logic [DATA_W-1:0]           xIn,
  input  logic [DATA_W-1:0]           yIn,
  input  logic                        accEn,
  input  logic                        subEn,
  input  logic                        signedMode,
  input  logic                        roundEn,
  input  logic [2*DATA_W+GUARD_W-1:0] preloadValue,
  output logic [GUARD_W-1:0]          resultExt,
  output logic [DATA_W-1:0]           resultHigh,
  output logic [DATA_W-1:0]           resultLow
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + GUARD_W;

  macStrobes_t      strobes;
  macModes_t        modes;
  logic [ACC_W-1:0] result;

  mac_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .loadX      (loadX),
    .loadY      (loadY),
    .loadP      (loadP),
    .preload    (preload),
    .accEn      (accEn),
    .subEn      (subEn),
    .signedMode (signedMode),
    .roundEn    (roundEn),
    .strobes    (strobes),
    .modes      (modes)
  );

  mac_datapath #(
    .DATA_W  (DATA_W),
    .GUARD_W (GUARD_W)
  ) u_datapath (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .modes        (modes),
    .xIn          (xIn),
    .yIn          (yIn),
    .preloadValue (preloadValue),
    .result       (result)
  );

  // Field split of the result register, R12
  assign resultExt  = result[ACC_W-1:PROD_W];
  assign resultHigh = result[PROD_W-1:DATA_W];
  assign resultLow  = result[DATA_W-1:0];

endmodule

// File: tb/mac_unit_bench.sv
module mac_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;
  localparam logic [15:0] PATS [9] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
                                       16'h8000, 16'h8001, 16'hFFFF, 16'h1234, 16'hABCD};

  logic        clk = 0;
  logic        rst = 1;
  logic        loadX = 0, loadY = 0, loadP = 0, preload = 0;
  logic [15:0] xIn = 0, yIn = 0;
  logic        accEn = 0, subEn = 0, signedMode = 0, roundEn = 0;
  logic [34:0] preloadValue = 0;
  logic [2:0]  resultExt;
  logic [15:0] resultHigh, resultLow;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_unit u_mac_unit (
    .clk(clk), .rst(rst), .loadX(loadX), .loadY(loadY), .loadP(loadP),
    .preload(preload), .xIn(xIn), .yIn(yIn), .accEn(accEn), .subEn(subEn),
    .signedMode(signedMode), .roundEn(roundEn), .preloadValue(preloadValue),
    .resultExt(resultExt), .resultHigh(resultHigh), .resultLow(resultLow)
  );

  function automatic logic [34:0] expProd(logic [15:0] a, logic [15:0] b, bit tc, bit rnd);
    longint pa = tc ? longint'($signed(a)) : longint'(a);
    longint pb = tc ? longint'($signed(b)) : longint'(b);
    longint p  = pa * pb + (rnd ? 64'sd32768 : 64'sd0);
    return p[34:0];
  endfunction

  task automatic check(string req, logic [34:0] exp);
    logic [34:0] got = {resultExt, resultHigh, resultLow};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic checkField(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic loadOps(logic [15:0] x, logic [15:0] y, bit ldx, bit ldy,
                         bit acc, bit sub, bit tc, bit rnd);
    xIn = x; yIn = y; loadX = ldx; loadY = ldy;
    accEn = acc; subEn = sub; signedMode = tc; roundEn = rnd;
    @(negedge clk);
    loadX = 0; loadY = 0;
  endtask

  task automatic pulseP();
    loadP = 1;
    @(negedge clk);
    loadP = 0;
  endtask

  task automatic doPreload(logic [34:0] v, bit alsoP);
    preloadValue = v; preload = 1; loadP = alsoP;
    @(negedge clk);
    preload = 0; loadP = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset state", 35'h0);

    // Sweep corner operands in both signedness modes, with and without rounding;
    // subtract alternates to show it is ignored with accumulate off
    for (int tc = 0; tc < 2; tc++) begin
      for (int rnd = 0; rnd < 2; rnd++) begin
        for (int i = 0; i < 9; i++) begin
          for (int j = 0; j < 9; j++) begin
            loadOps(PATS[i], PATS[j], 1, 1, 0, (i + j) % 2, tc[0], rnd[0]);
            pulseP();
            check("R5 R6 R9 product sweep", expProd(PATS[i], PATS[j], tc[0], rnd[0]));
          end
        end
      end
    end

    // Most negative squared, signed
    loadOps(16'h8000, 16'h8000, 1, 1, 0, 0, 1, 0);
    pulseP();
    check("R7 -32768 squared", 35'h0_4000_0000);

    // Field split
    doPreload({3'd5, 16'h1234, 16'hABCD}, 0);
    checkField("R12 ext field", {13'd0, resultExt}, 16'd5);
    checkField("R12 high field", resultHigh, 16'h1234);
    checkField("R12 low field", resultLow, 16'hABCD);

    // Modes come from the register, not live inputs
    loadOps(16'hFFFF, 16'h0002, 1, 1, 0, 0, 1, 0);
    signedMode = 0; accEn = 1; subEn = 1;
    pulseP();
    check("R3 latched modes", 35'h7_FFFF_FFFE);

    // Load X only: Y keeps 2
    loadOps(16'h0003, 16'h0055, 1, 0, 0, 0, 0, 0);
    pulseP();
    check("R2 Y retained", 35'd6);

    // Operand loads without loadP leave the result alone
    loadOps(16'h0007, 16'h0007, 1, 1, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    check("R4 hold without loadP", 35'd6);
    pulseP();
    check("R4 update on loadP", 35'd49);

    // Accumulate and subtract ordering
    loadOps(16'd3, 16'd4, 1, 1, 0, 0, 0, 0);
    pulseP();
    check("R5 plain multiply", 35'd12);
    loadOps(16'd5, 16'd6, 1, 1, 1, 0, 0, 0);
    pulseP();
    check("R8 accumulate add", 35'd42);
    loadOps(16'd2, 16'd2, 1, 1, 1, 1, 0, 0);
    pulseP();
    check("R8 product minus previous", 35'h7_FFFF_FFDA);
    loadOps(16'hFFFF, 16'h0003, 1, 1, 1, 0, 1, 0);
    pulseP();
    check("R8 signed accumulate", 35'h7_FFFF_FFD7);
    loadOps(16'd0, 16'd0, 1, 1, 1, 0, 0, 1);
    pulseP();
    check("R9 round while accumulating", 35'h0_0000_7FD7);

    // Wrap modulo 2^35
    doPreload(35'h7_FFFF_FFFF, 0);
    loadOps(16'd1, 16'd1, 1, 1, 1, 0, 0, 0);
    pulseP();
    check("R10 add wraps", 35'h0);
    doPreload(35'd1, 0);
    loadOps(16'd0, 16'd0, 1, 1, 1, 1, 0, 0);
    pulseP();
    check("R10 subtract wraps", 35'h7_FFFF_FFFF);

    // Preload beats loadP
    loadOps(16'd9, 16'd9, 1, 1, 0, 0, 0, 0);
    doPreload(35'h2_0000_0001, 1);
    check("R11 preload priority", 35'h2_0000_0001);
    pulseP();
    check("R11 loadP after preload", 35'd81);

    // Mid-run reset clears operands, modes and result
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 reset clears result", 35'h0);
    accEn = 1; roundEn = 1;
    pulseP();
    check("R1 cleared operands and modes", 35'h0);

    done = 1;
    summary();
    $finish;
  end

endmodule